// File: doc/BRIEF.md
# Address-space-tagged translation cache

This block caches recent virtual-to-physical page translations in a small fully associative array. Each slot records a virtual page number, a physical frame number, an address-space tag, a page size and valid/used state. A lookup presents a 48-bit virtual address with the running address-space tag. One cycle later the block reports a hit with the physical address, or a miss. Translations for several address spaces can sit in the array together, so a context switch needs no flush.

A miss handler installs translations through the fill port. Software-driven maintenance uses the single-page invalidate port, which can be limited to one address space or applied to all of them, and the flush input, which empties the array. When a fill finds the array full, it evicts a slot chosen from per-slot used bits that implement a pseudo-LRU policy. Saturating hit and miss counters are exposed at the outputs.

Top module: `asid_tlb`

## Requirements
- R1: After reset, `hit_o`, `miss_o`, `pa_o` and both counters are zero, and every slot is invalid, so the first lookup misses.
- R2: A lookup hits only if a slot is valid, its tag equals `lookup_asid_i` and its page number matches. `hit_o` or `miss_o` (never both) is high for one cycle, in the cycle after `lookup_valid_i`. Both stay low when no lookup was made. If several slots match, the lowest index wins.
- R3: `fill_size_i` selects the page size: 0 = 4KB (12 offset bits), 1 = 2MB (21), 2 = 1GB (30); code 3 is treated as 4KB. Only address bits above the offset take part in any compare. On a hit, `pa_o` is the stored frame shifted left by 12, with the offset bits taken from the lookup address. `pa_o` is zero on a miss.
- R4: A fill whose tag, size and page number match a valid slot overwrites that slot. Otherwise the fill goes to the lowest-index invalid slot.
- R5: If no slot is invalid, the fill evicts the lowest-index slot whose used bit is clear. A hit or a fill sets the touched slot's used bit. When that would set all used bits, only the bits touched in that cycle stay set.
- R6: A single-page invalidate clears every valid slot whose page number, compared at the slot's own size, matches `inval_va_i`, and whose tag equals `inval_asid_i`. When `inval_all_asid_i` is high the tag is not compared. No other slot changes.
- R7: A flush clears the valid and used bits of every slot.
- R8: Within one cycle, flush takes priority over invalidate, which takes priority over fill. The lower-priority operation is dropped. A lookup in the same cycle sees the array as it was before that cycle's update.
- R9: `hit_cnt_o` and `miss_cnt_o` count hits and misses. Each is `CNT_W` bits wide (default 32) and saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_valid_i | input | 1 | Lookup request |
| lookup_va_i | input | VA_W | Virtual address to translate |
| lookup_asid_i | input | ASID_W | Running address-space tag |
| fill_i | input | 1 | Install a translation |
| fill_va_i | input | VA_W | Virtual address of the fill |
| fill_ppn_i | input | PA_W-12 | Physical frame number (4KB units) |
| fill_asid_i | input | ASID_W | Tag of the fill |
| fill_size_i | input | 2 | Page size code |
| inval_i | input | 1 | Invalidate one page |
| inval_va_i | input | VA_W | Virtual address to invalidate |
| inval_asid_i | input | ASID_W | Tag to invalidate |
| inval_all_asid_i | input | 1 | Ignore the tag on invalidate |
| flush_i | input | 1 | Invalidate all slots |
| hit_o | output | 1 | Lookup hit, one cycle after request |
| miss_o | output | 1 | Lookup miss, one cycle after request |
| pa_o | output | PA_W | Translated physical address |
| hit_cnt_o | output | CNT_W | Saturating hit count |
| miss_cnt_o | output | CNT_W | Saturating miss count |

## Verification
The bench targets the following corner cases:
- Overlapping pages of different sizes: a design that masks the compare with the wrong size returns a neighbour's frame, or misses inside a large page.
- Refilling an existing translation: creating a duplicate instead of overwriting leaves the stale frame visible at the lower index.
- Eviction after sixteen fills: the seventeenth fill must replace slot 0. Getting the used-bit reset wrong evicts a recently used slot.
- Collisions between lookups, fills, invalidates and flushes in one cycle: a wrong priority or a lookup that sees post-update state changes a hit/miss result.
- Counter saturation: a counter that is not held at its limit wraps to zero.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

  localparam int unsigned PG_OFF_W     = 12;
  localparam int unsigned PG_MAX_OFF_W = 30;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_2M  = 2'd1,
    PG_1G  = 2'd2,
    PG_RSV = 2'd3
  } pg_size_e;

  // extra page-number bits ignored beyond the 4KB offset
  function automatic int unsigned pg_shift(pg_size_e s);
    case (s)
      PG_2M:   return 9;
      PG_1G:   return 18;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/asid_tlb_entry.sv
module asid_tlb_entry
  import asid_tlb_pkg::*;
#(
  parameter int unsigned VPN_W  = 36,
  parameter int unsigned PPN_W  = 40,
  parameter int unsigned ASID_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              clr_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [PPN_W-1:0]  wr_ppn_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  pg_size_e          wr_size_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic [VPN_W-1:0]  inv_vpn_i,
  input  logic [ASID_W-1:0] inv_asid_i,
  input  logic              inv_all_i,
  output logic              valid_o,
  output logic              lk_hit_o,
  output logic              inv_hit_o,
  output logic              fill_hit_o,
  output logic [PPN_W-1:0]  ppn_o,
  output pg_size_e          size_o
);

  logic              valid_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [PPN_W-1:0]  ppn_q;
  logic [ASID_W-1:0] asid_q;
  pg_size_e          size_q;
  logic [VPN_W-1:0]  cmp_mask;

  assign cmp_mask = {VPN_W{1'b1}} << pg_shift(size_q);

  assign lk_hit_o   = valid_q && (asid_q == lk_asid_i) &&
                      (((vpn_q ^ lk_vpn_i) & cmp_mask) == '0);
  assign inv_hit_o  = valid_q && (inv_all_i || (asid_q == inv_asid_i)) &&
                      (((vpn_q ^ inv_vpn_i) & cmp_mask) == '0);
  assign fill_hit_o = valid_q && (asid_q == wr_asid_i) && (size_q == wr_size_i) &&
                      (((vpn_q ^ wr_vpn_i) & cmp_mask) == '0);

  assign valid_o = valid_q;
  assign ppn_o   = ppn_q;
  assign size_o  = size_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      vpn_q   <= '0;
      ppn_q   <= '0;
      asid_q  <= '0;
      size_q  <= PG_4K;
    end else if (clr_i) begin
      valid_q <= 1'b0;
    end else if (wr_i) begin
      valid_q <= 1'b1;
      vpn_q   <= wr_vpn_i;
      ppn_q   <= wr_ppn_i;
      asid_q  <= wr_asid_i;
      size_q  <= wr_size_i;
    end
  end

endmodule

// File: rtl/asid_tlb_victim.sv
module asid_tlb_victim #(
  parameter int unsigned N_ENTRIES = 16,
  localparam int unsigned IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic [N_ENTRIES-1:0] valid_i,
  input  logic [N_ENTRIES-1:0] used_i,
  output logic [IDX_W-1:0]     idx_o
);

  logic any_free;

  // lowest invalid slot first, else lowest slot with used clear
  always_comb begin
    idx_o    = '0;
    any_free = 1'b0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (!used_i[i]) idx_o = IDX_W'(i);
    end
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        idx_o    = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  logic unused_free;
  assign unused_free = any_free;

endmodule

// File: rtl/asid_tlb_sat_cnt.sv
module asid_tlb_sat_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_o <= '0;
    else if (inc_i && cnt_o != '1)  cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned VA_W      = 48,
  parameter int unsigned PA_W      = 52,
  parameter int unsigned ASID_W    = 8,
  parameter int unsigned CNT_W     = 32,
  localparam int unsigned VPN_W    = VA_W - PG_OFF_W,
  localparam int unsigned PPN_W    = PA_W - PG_OFF_W,
  localparam int unsigned IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_valid_i,
  input  logic [VA_W-1:0]   lookup_va_i,
  input  logic [ASID_W-1:0] lookup_asid_i,
  input  logic              fill_i,
  input  logic [VA_W-1:0]   fill_va_i,
  input  logic [PPN_W-1:0]  fill_ppn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [1:0]        fill_size_i,
  input  logic              inval_i,
  input  logic [VA_W-1:0]   inval_va_i,
  input  logic [ASID_W-1:0] inval_asid_i,
  input  logic              inval_all_asid_i,
  input  logic              flush_i,
  output logic              hit_o,
  output logic              miss_o,
  output logic [PA_W-1:0]   pa_o,
  output logic [CNT_W-1:0]  hit_cnt_o,
  output logic [CNT_W-1:0]  miss_cnt_o
);

  logic [N_ENTRIES-1:0] valid_vec, lk_hit_vec, inv_hit_vec, fill_hit_vec;
  logic [N_ENTRIES-1:0] wr_vec, clr_vec, touch_vec, used_q, used_n;
  logic [PPN_W-1:0]     ppn_arr  [N_ENTRIES];
  pg_size_e             size_arr [N_ENTRIES];
  logic [IDX_W-1:0]     victim_idx, fill_idx, lk_idx;
  logic                 do_flush, do_inv, do_fill, lk_any;
  pg_size_e             fill_size;
  logic [PA_W-1:0]      off_mask, pa_c;

  assign fill_size = pg_size_e'(fill_size_i);

  // one maintenance op per cycle: flush > invalidate > fill
  assign do_flush = flush_i;
  assign do_inv   = inval_i & ~flush_i;
  assign do_fill  = fill_i & ~flush_i & ~inval_i;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
    asid_tlb_entry #(
      .VPN_W (VPN_W),
      .PPN_W (PPN_W),
      .ASID_W(ASID_W)
    ) i_entry (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_vec[g]),
      .clr_i     (clr_vec[g]),
      .wr_vpn_i  (fill_va_i[VA_W-1:PG_OFF_W]),
      .wr_ppn_i  (fill_ppn_i),
      .wr_asid_i (fill_asid_i),
      .wr_size_i (fill_size),
      .lk_vpn_i  (lookup_va_i[VA_W-1:PG_OFF_W]),
      .lk_asid_i (lookup_asid_i),
      .inv_vpn_i (inval_va_i[VA_W-1:PG_OFF_W]),
      .inv_asid_i(inval_asid_i),
      .inv_all_i (inval_all_asid_i),
      .valid_o   (valid_vec[g]),
      .lk_hit_o  (lk_hit_vec[g]),
      .inv_hit_o (inv_hit_vec[g]),
      .fill_hit_o(fill_hit_vec[g]),
      .ppn_o     (ppn_arr[g]),
      .size_o    (size_arr[g])
    );
  end

  asid_tlb_victim #(
    .N_ENTRIES(N_ENTRIES)
  ) i_victim (
    .valid_i(valid_vec),
    .used_i (used_q),
    .idx_o  (victim_idx)
  );

  // lowest-index match wins for lookups and refills
  always_comb begin
    lk_idx   = '0;
    fill_idx = victim_idx;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (lk_hit_vec[i])   lk_idx   = IDX_W'(i);
      if (fill_hit_vec[i]) fill_idx = IDX_W'(i);
    end
  end

  assign lk_any = lookup_valid_i & (|lk_hit_vec);

  always_comb begin
    for (int i = 0; i < N_ENTRIES; i++) begin
      wr_vec[i]  = do_fill && (fill_idx == IDX_W'(i));
      clr_vec[i] = do_flush || (do_inv && inv_hit_vec[i]);
    end
    touch_vec = wr_vec;
    if (lk_any) touch_vec[lk_idx] = 1'b1;
  end

  // pseudo-LRU used bits
  always_comb begin
    used_n = used_q | touch_vec;
    if (&used_n) used_n = touch_vec;
    if (do_inv)  used_n = used_n & ~inv_hit_vec;
    if (do_flush) used_n = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) used_q <= '0;
    else         used_q <= used_n;
  end

  assign off_mask = ~({PA_W{1'b1}} << (PG_OFF_W + pg_shift(size_arr[lk_idx])));
  assign pa_c     = ({ppn_arr[lk_idx], {PG_OFF_W{1'b0}}} & ~off_mask) |
                    (PA_W'(lookup_va_i[PG_MAX_OFF_W-1:0]) & off_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o  <= 1'b0;
      miss_o <= 1'b0;
      pa_o   <= '0;
    end else begin
      hit_o  <= lk_any;
      miss_o <= lookup_valid_i & ~lk_any;
      pa_o   <= lk_any ? pa_c : '0;
    end
  end

  asid_tlb_sat_cnt #(.CNT_W(CNT_W)) i_hit_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (lk_any),
    .cnt_o (hit_cnt_o)
  );

  asid_tlb_sat_cnt #(.CNT_W(CNT_W)) i_miss_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (lookup_valid_i & ~lk_any),
    .cnt_o (miss_cnt_o)
  );

  logic unused_lo;
  assign unused_lo = ^{fill_va_i[PG_OFF_W-1:0], inval_va_i[PG_OFF_W-1:0]};

endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int unsigned N     = 16,
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lookup_valid_i,
  input logic             fill_i,
  input logic             inval_i,
  input logic             flush_i,
  input logic             hit_o,
  input logic             miss_o,
  input logic [CNT_W-1:0] hit_cnt_o,
  input logic [CNT_W-1:0] miss_cnt_o,
  input logic [N-1:0]     valid_i,
  input logic [N-1:0]     used_i
);

  // R2
  hit_miss_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && miss_o));

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |=> (!hit_o && !miss_o));

  // R7
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_i == '0));

  // R4
  fill_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !inval_i && !flush_i) |=> (valid_i != '0));

  // R5
  used_not_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used_i != '1);

  // R9
  hit_cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && $past(hit_cnt_o) != '1) |-> (hit_cnt_o == $past(hit_cnt_o) + 1'b1));

  // R9
  miss_cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_o && $past(miss_cnt_o) != '1) |-> (miss_cnt_o == $past(miss_cnt_o) + 1'b1));

endmodule

bind asid_tlb asid_tlb_chk #(
  .N    (N_ENTRIES),
  .CNT_W(CNT_W)
) i_asid_tlb_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .lookup_valid_i(lookup_valid_i),
  .fill_i        (fill_i),
  .inval_i       (inval_i),
  .flush_i       (flush_i),
  .hit_o         (hit_o),
  .miss_o        (miss_o),
  .hit_cnt_o     (hit_cnt_o),
  .miss_cnt_o    (miss_cnt_o),
  .valid_i       (valid_vec),
  .used_i        (used_q)
);

// File: tb/test_asid_tlb.sv
module test_asid_tlb;

  localparam int NE    = 16;
  localparam int CNT_W = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lk_v = 1'b0;
  logic [47:0] lk_va = '0;
  logic [7:0]  lk_asid = '0;
  logic        f_v = 1'b0;
  logic [47:0] f_va = '0;
  logic [39:0] f_ppn = '0;
  logic [7:0]  f_asid = '0;
  logic [1:0]  f_size = '0;
  logic        i_v = 1'b0;
  logic [47:0] i_va = '0;
  logic [7:0]  i_asid = '0;
  logic        i_all = 1'b0;
  logic        fl_v = 1'b0;
  logic        hit_o, miss_o;
  logic [51:0] pa_o;
  logic [CNT_W-1:0] hit_cnt_o, miss_cnt_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // reference state
  bit          m_valid [NE];
  logic [35:0] m_vpn   [NE];
  logic [39:0] m_ppn   [NE];
  logic [7:0]  m_asid  [NE];
  int          m_size  [NE];
  bit [NE-1:0] m_used;
  int          m_hits, m_miss;

  always #10 clk_i = ~clk_i;

  asid_tlb #(.CNT_W(CNT_W)) i_asid_tlb (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lookup_valid_i(lk_v), .lookup_va_i(lk_va), .lookup_asid_i(lk_asid),
    .fill_i(f_v), .fill_va_i(f_va), .fill_ppn_i(f_ppn), .fill_asid_i(f_asid),
    .fill_size_i(f_size),
    .inval_i(i_v), .inval_va_i(i_va), .inval_asid_i(i_asid),
    .inval_all_asid_i(i_all), .flush_i(fl_v),
    .hit_o(hit_o), .miss_o(miss_o), .pa_o(pa_o),
    .hit_cnt_o(hit_cnt_o), .miss_cnt_o(miss_cnt_o)
  );

  function automatic int shift_of(int s);
    return (s == 1) ? 9 : (s == 2) ? 18 : 0;
  endfunction

  function automatic logic [35:0] vmask(int s);
    return {36{1'b1}} << shift_of(s);
  endfunction

  function automatic logic [51:0] omask(int s);
    return ~({52{1'b1}} << (12 + shift_of(s)));
  endfunction

  function automatic bit vmatch(int e, logic [47:0] va);
    return ((m_vpn[e] ^ va[47:12]) & vmask(m_size[e])) == '0;
  endfunction

  task automatic check(string req, bit ok, string got, string exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %s expected %s", req, got, exp);
    end
  endtask

  task automatic idle();
    lk_v = 0; f_v = 0; i_v = 0; fl_v = 0; i_all = 0;
  endtask

  task automatic model_update(bit eh, int ei);
    bit [NE-1:0] touch, clr;
    int fidx;
    touch = '0; clr = '0;
    if (eh) touch[ei] = 1'b1;
    if (fl_v) begin
      for (int e = 0; e < NE; e++) m_valid[e] = 0;
      m_used = '0;
      return;
    end
    if (i_v) begin
      for (int e = 0; e < NE; e++)
        if (m_valid[e] && (i_all || m_asid[e] == i_asid) && vmatch(e, i_va)) clr[e] = 1'b1;
    end else if (f_v) begin
      fidx = -1;
      for (int e = NE - 1; e >= 0; e--)
        if (m_valid[e] && m_asid[e] == f_asid && m_size[e] == int'(f_size) &&
            (((m_vpn[e] ^ f_va[47:12]) & vmask(int'(f_size))) == '0)) fidx = e;
      if (fidx < 0) for (int e = NE - 1; e >= 0; e--) if (!m_valid[e]) fidx = e;
      if (fidx < 0) for (int e = NE - 1; e >= 0; e--) if (!m_used[e]) fidx = e;
      if (fidx < 0) fidx = 0;
      m_valid[fidx] = 1; m_vpn[fidx] = f_va[47:12]; m_ppn[fidx] = f_ppn;
      m_asid[fidx] = f_asid; m_size[fidx] = int'(f_size);
      touch[fidx] = 1'b1;
    end
    m_used = m_used | touch;
    if (&m_used) m_used = touch;
    m_used = m_used & ~clr;
    for (int e = 0; e < NE; e++) if (clr[e]) m_valid[e] = 0;
  endtask

  // one clock: expectation from pre-edge model, check after the edge
  task automatic tick(string req);
    bit eh;
    int ei;
    logic [51:0] ep;
    eh = 0; ei = 0;
    if (lk_v)
      for (int e = NE - 1; e >= 0; e--)
        if (m_valid[e] && m_asid[e] == lk_asid && vmatch(e, lk_va)) begin
          eh = 1; ei = e;
        end
    ep = eh ? (({m_ppn[ei], 12'h0} & ~omask(m_size[ei])) |
               ({22'h0, lk_va[29:0]} & omask(m_size[ei]))) : '0;
    @(posedge clk_i);
    model_update(eh, ei);
    if (lk_v && eh  && m_hits < (1 << CNT_W) - 1) m_hits++;
    if (lk_v && !eh && m_miss < (1 << CNT_W) - 1) m_miss++;
    @(negedge clk_i);
    check(req, hit_o == eh && miss_o == (lk_v && !eh) && pa_o == ep &&
               hit_cnt_o == CNT_W'(m_hits) && miss_cnt_o == CNT_W'(m_miss),
          $sformatf("hit=%0b miss=%0b pa=%h hc=%0d mc=%0d", hit_o, miss_o, pa_o, hit_cnt_o, miss_cnt_o),
          $sformatf("hit=%0b miss=%0b pa=%h hc=%0d mc=%0d", eh, lk_v && !eh, ep, m_hits, m_miss));
    idle();
  endtask

  task automatic set_lk(logic [47:0] va, logic [7:0] a);
    lk_v = 1; lk_va = va; lk_asid = a;
  endtask

  task automatic set_fill(logic [47:0] va, logic [39:0] p, logic [7:0] a, logic [1:0] s);
    f_v = 1; f_va = va; f_ppn = p; f_asid = a; f_size = s;
  endtask

  task automatic set_inv(logic [47:0] va, logic [7:0] a, bit all);
    i_v = 1; i_va = va; i_asid = a; i_all = all;
  endtask

  function automatic logic [47:0] rand_va();
    int k;
    k = $urandom_range(0, 59);
    return (48'(k % 6) << 30) | (48'((k / 6) % 4) << 21) | (48'(k % 5) << 12) |
           48'($urandom_range(0, 4095));
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int e = 0; e < NE; e++) begin
      m_valid[e] = 0; m_vpn[e] = '0; m_ppn[e] = '0; m_asid[e] = '0; m_size[e] = 0;
    end
    m_used = '0; m_hits = 0; m_miss = 0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1", hit_o == 0 && miss_o == 0 && pa_o == 0 && hit_cnt_o == 0 && miss_cnt_o == 0,
          $sformatf("%0b %0b %h %0d %0d", hit_o, miss_o, pa_o, hit_cnt_o, miss_cnt_o), "0 0 0 0 0");
    rst_ni = 1'b1;
    @(negedge clk_i);
    set_lk(48'h0000_1234_5678, 8'd1); tick("R1");
    tick("R2");

    // R3 page sizes
    set_fill(48'h0000_1234_5000, 40'hA_BCDE, 8'd1, 2'd0); tick("R3");
    set_fill(48'h0000_4020_0000, 40'h1_1200, 8'd1, 2'd1); tick("R3");
    set_fill(48'h0080_4000_0000, 40'h7_7400, 8'd1, 2'd2); tick("R3");
    set_lk(48'h0000_1234_5ABC, 8'd1); tick("R3");
    set_lk(48'h0000_403F_F123, 8'd1); tick("R3");
    set_lk(48'h0080_7FFF_FFFF, 8'd1); tick("R3");
    set_lk(48'h0000_1234_5ABC, 8'd2); tick("R2");
    set_lk(48'h0000_1234_6ABC, 8'd1); tick("R2");

    // R4 refill overwrites
    set_fill(48'h0000_1234_5000, 40'h5_5555, 8'd1, 2'd0); tick("R4");
    set_lk(48'h0000_1234_5010, 8'd1); tick("R4");

    // R6 single-page invalidate
    set_inv(48'h0000_1234_5000, 8'd2, 0); tick("R6");
    set_lk(48'h0000_1234_5010, 8'd1); tick("R6");
    set_inv(48'h0000_1234_5000, 8'd9, 1); tick("R6");
    set_lk(48'h0000_1234_5010, 8'd1); tick("R6");
    set_inv(48'h0000_4031_0000, 8'd1, 0); tick("R6");
    set_lk(48'h0000_4020_0000, 8'd1); tick("R6");
    set_lk(48'h0080_4000_0000, 8'd1); tick("R6");

    // R7 flush
    fl_v = 1; tick("R7");
    set_lk(48'h0080_4000_0000, 8'd1); tick("R7");

    // R5 replacement after filling every slot
    for (int e = 0; e < NE; e++) begin
      set_fill(48'(36'h100 + e) << 12, 40'(e + 1), 8'd0, 2'd0); tick("R5");
    end
    set_fill(48'h0000_0020_0000, 40'hBEEF, 8'd0, 2'd0); tick("R5");
    set_lk(48'h0000_0010_0000, 8'd0); tick("R5");
    set_lk(48'h0000_0010_1000, 8'd0); tick("R5");
    set_lk(48'h0000_0020_0000, 8'd0); tick("R5");

    // R8 same-cycle collisions
    set_fill(48'h0000_0030_0000, 40'h333, 8'd0, 2'd0);
    set_lk(48'h0000_0030_0000, 8'd0); tick("R8");
    set_lk(48'h0000_0030_0000, 8'd0); tick("R8");
    set_inv(48'h0000_0030_0000, 8'd0, 0);
    set_fill(48'h0000_0040_0000, 40'h444, 8'd0, 2'd0); tick("R8");
    set_lk(48'h0000_0040_0000, 8'd0); tick("R8");
    fl_v = 1; set_fill(48'h0000_0050_0000, 40'h555, 8'd0, 2'd0);
    set_lk(48'h0000_0010_1000, 8'd0); tick("R8");
    set_lk(48'h0000_0050_0000, 8'd0); tick("R8");

    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 1) fl_v = 1;
      else if (r < 9) set_inv(rand_va(), 8'($urandom_range(0, 2)), $urandom_range(0, 3) == 0);
      else if (r < 34) set_fill(rand_va(), {$urandom, $urandom}[39:0],
                                8'($urandom_range(0, 2)), 2'($urandom_range(0, 2)));
      if ($urandom_range(0, 9) < 7) set_lk(rand_va(), 8'($urandom_range(0, 2)));
      tick("R2");
    end

    // R9 saturation
    set_fill(48'h0000_0060_0000, 40'h666, 8'd3, 2'd0); tick("R9");
    for (int n = 0; n < 300; n++) begin
      set_lk(48'h0000_0060_0000, 8'd3); tick("R9");
    end
    check("R9", hit_cnt_o == '1 && miss_cnt_o == '1,
          $sformatf("hc=%0d mc=%0d", hit_cnt_o, miss_cnt_o), "hc=255 mc=255");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule